// File: doc/BRIEF.md
# Supply Monitor Interrupt Controller

This block is the control and status register for a brownout supply monitor. An analog comparator outside the block reports whether the supply is above a selected threshold. The block brings that signal into the clock domain through a synchronizer. It holds a monitor-enable bit and a threshold-select bit, and both drive the comparator directly. It also keeps a sticky low-supply flag that raises a level interrupt request toward an external interrupt controller.

Software reads and writes the block through one 8-bit register port. The flag is cleared by writing 1 to its bit, and the clear is accepted only while the comparator status reads high, which means the supply has recovered or the monitor is off. An arming bit stops a second interrupt from being raised until the synchronized comparator has actually been seen high. Toggling the enable during a single low period therefore cannot raise the flag twice.

Register layout: bit 0 is the low-supply flag (read, write-1-to-clear). Bit 1 is the monitor enable (read/write). Bit 2 is the threshold select, where 0 picks the lower and 1 the higher trip point (read/write). Bit 3 is the comparator status (read-only). Bits 7:4 are reserved.

Top module: `psm_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no writes, `rdata` reads 0x08, `mon_en`, `trip_hi` and `irq` are 0.
- R2: Bits 7:4 of `rdata` always read 0, whatever value was written to them.
- R3: A write sets `mon_en` to `wdata[1]` and `trip_hi` to `wdata[2]` from the next cycle on, and both read back on `rdata[1]` and `rdata[2]`.
- R4: `rdata[3]` reads 1 whenever `mon_en` is 0. While `mon_en` is 1 it reads the comparator input delayed by two clock edges of synchronization.
- R5: While enabled and armed, a low status sets the flag `rdata[0]` one edge later, which is three edges after `cmp_async` falls. The flag stays set without further stimulus.
- R6: A write with `wdata[0]`=1 while `rdata[3]` is 1 clears the flag at that edge, including in the first cycle the recovered status shows. A write with `wdata[0]`=0 leaves the flag unchanged.
- R7: A write with `wdata[0]`=1 while `rdata[3]` is 0 does not clear the flag.
- R8: After the flag is set, it is not set again until the synchronized comparator has been seen high. This holds even if the monitor is disabled, the flag is cleared and the monitor is re-enabled while the comparator is still low.
- R9: `irq` equals `rdata[0]` AND `irq_en` as a combinational level.
- R10: While `mon_en` is 0 the flag is never set, whatever the comparator input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_async | input | 1 | Raw comparator output, 1 = supply above trip point |
| irq_en | input | 1 | Interrupt enable from the interrupt controller |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| mon_en | output | 1 | Enable to the comparator |
| trip_hi | output | 1 | Threshold select to the comparator, 1 = higher |
| irq | output | 1 | Level interrupt request |

## Verification
Every one of the 256 write values is applied with a healthy supply. This separates the writable control bits from the reserved and read-only bits and from the write-1-to-clear flag. All eight combinations of enable, comparator level and interrupt enable are then applied, and each must give the computed status, flag and request. This tells a status forced high by disabling apart from a synchronized comparator reading. Directed sequences time the comparator fall edge by edge. They try clears both before and at the first recovered cycle, and disable, clear and re-enable within one low period, which shows that the arming bit blocks a retrigger.

// File: rtl/psm_pkg.sv
package psm_pkg;
  localparam int DATA_W   = 8;
  localparam int BIT_FLAG = 0;
  localparam int BIT_EN   = 1;
  localparam int BIT_TRIP = 2;
  localparam int BIT_STAT = 3;

  typedef struct packed {
    logic trip_hi;
    logic mon_en;
  } psm_ctl_t;
endpackage

// File: rtl/psm_rst_sync.sv
module psm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/psm_sync.sv
module psm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_nxt;

  always_comb begin
    stage_nxt = {stage_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= stage_nxt;
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/psm_regfile.sv
module psm_regfile
  import psm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              status,
  input  logic              flag,
  output psm_ctl_t          ctl,
  output logic              clr_req,
  output logic [DATA_W-1:0] rdata
);
  psm_ctl_t ctl_q;
  psm_ctl_t ctl_nxt;
  logic     wdata_unused;

  assign wdata_unused = ^wdata[DATA_W-1:BIT_STAT];

  always_comb begin
    ctl_nxt         = ctl_q;
    ctl_nxt.mon_en  = wdata[BIT_EN];
    ctl_nxt.trip_hi = wdata[BIT_TRIP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_nxt;
  end

  assign clr_req = wr_en & wdata[BIT_FLAG];
  assign ctl     = ctl_q;

  always_comb begin
    rdata           = '0;
    rdata[BIT_FLAG] = flag;
    rdata[BIT_EN]   = ctl_q.mon_en;
    rdata[BIT_TRIP] = ctl_q.trip_hi;
    rdata[BIT_STAT] = status;
  end
endmodule

// File: rtl/psm_flag.sv
module psm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic cmp_sync,
  input  logic clr_req,
  output logic status,
  output logic flag
);
  logic flag_q, flag_nxt;
  logic armed_q, armed_nxt;
  logic set_cond;
  logic clr_ok;

  assign status   = cmp_sync | ~mon_en;
  assign set_cond = ~status & armed_q;
  assign clr_ok   = clr_req & status;

  always_comb begin
    flag_nxt  = flag_q;
    armed_nxt = armed_q;
    if (clr_ok)   flag_nxt = 1'b0;
    if (set_cond) flag_nxt = 1'b1;
    if (set_cond)      armed_nxt = 1'b0;
    else if (cmp_sync) armed_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      flag_q  <= flag_nxt;
      armed_q <= armed_nxt;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/psm_ctrl.sv
module psm_ctrl
  import psm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_async,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              mon_en,
  output logic              trip_hi,
  output logic              irq
);
  logic     rst_n_i;
  logic     cmp_sync;
  logic     status;
  logic     flag;
  logic     clr_req;
  psm_ctl_t ctl;

  psm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  psm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .d_async (cmp_async),
    .q_sync  (cmp_sync)
  );

  psm_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .status  (status),
    .flag    (flag),
    .ctl     (ctl),
    .clr_req (clr_req),
    .rdata   (rdata)
  );

  psm_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .mon_en   (ctl.mon_en),
    .cmp_sync (cmp_sync),
    .clr_req  (clr_req),
    .status   (status),
    .flag     (flag)
  );

  assign mon_en  = ctl.mon_en;
  assign trip_hi = ctl.trip_hi;
  assign irq     = flag & irq_en;
endmodule

// File: rtl/psm_ctrl_chk.sv
module psm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_en,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       mon_en,
  input logic       irq
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rdata[7:4] == 4'h0); // R2
  AST_STAT_DIS: assert property (@(posedge clk) disable iff (!rst_n) !mon_en |-> rdata[3]); // R4
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wdata[0] && rdata[3]) |=> !rdata[0]); // R6
  AST_W0_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wdata[0] && rdata[0]) |=> rdata[0]); // R6
  AST_NO_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n) (rdata[0] && !rdata[3]) |=> rdata[0]); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (irq_en && rdata[0])); // R9
  AST_DIS_NO_SET: assert property (@(posedge clk) disable iff (!rst_n) (!mon_en && !rdata[0]) |=> !rdata[0]); // R10
endmodule

bind psm_ctrl psm_ctrl_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq_en (irq_en),
  .wr_en  (wr_en),
  .wdata  (wdata),
  .rdata  (rdata),
  .mon_en (mon_en),
  .irq    (irq)
);

// File: tb/sim_psm_ctrl.sv
`timescale 1ns/1ps
module sim_psm_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmp_async;
  logic       irq_en;
  logic       wr_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       mon_en;
  logic       trip_hi;
  logic       irq;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  psm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmp_async(cmp_async), .irq_en(irq_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .mon_en(mon_en),
    .trip_hi(trip_hi), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    wdata = 8'h00;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmp_async = 1'b1; irq_en = 1'b1; wr_en = 1'b0; wdata = 8'h00;
    cyc(3);
    check("R1 reset rdata", rdata, 8'h08);
    check("R1 reset outs", {5'd0, mon_en, trip_hi, irq}, 8'h00);
    rst_n = 1'b1;
    cyc(4);
    check("R1 after release", rdata, 8'h08);

    // R2 R3: every write value with a healthy supply
    for (int d = 0; d < 256; d++) begin
      wr(d[7:0]);
      check("R2 R3 sweep rdata", rdata, 8'h08 | (d[7:0] & 8'h06));
      check("R3 sweep outs", {6'd0, trip_hi, mon_en}, {6'd0, d[2], d[1]});
    end

    // R4 R9 R10: all combinations of enable, comparator, irq enable
    for (int k = 0; k < 8; k++) begin
      logic en, c, ie, fl;
      en = k[2]; c = k[1]; ie = k[0];
      wr(8'h00);
      cmp_async = 1'b1;
      cyc(3);
      wr(8'h01);
      cyc(3);
      wr({6'd0, en, 1'b0});
      cmp_async = c; irq_en = ie;
      cyc(4);
      fl = en & ~c;
      check("R4 R10 combo rdata", rdata, {4'd0, ~en | c, 1'b0, en, fl});
      check("R9 combo irq", {7'd0, irq}, {7'd0, fl & ie});
    end

    // R5 timing of the set
    irq_en = 1'b1;
    wr(8'h00); cmp_async = 1'b1; cyc(3); wr(8'h01); cyc(3);
    wr(8'h02); cyc(2);
    cmp_async = 1'b0;
    cyc(1);
    check("R5 status after 1 edge", {7'd0, rdata[3]}, 8'h01);
    cyc(1);
    check("R5 status/flag after 2 edges", {6'd0, rdata[3], rdata[0]}, 8'h02 >> 1 & 8'h00);
    cyc(1);
    check("R5 flag after 3 edges", {7'd0, rdata[0]}, 8'h01);
    check("R9 irq level", {7'd0, irq}, 8'h01);
    cyc(5);
    check("R5 flag sticky", rdata, 8'h03);

    // R7 clear blocked while low
    wr(8'h03);
    check("R7 clear while low", rdata, 8'h03);

    // R6 write 0 no effect, immediate clear on recovery
    cmp_async = 1'b1;
    cyc(2);
    check("R6 recovered status", rdata, 8'h0B);
    wr(8'h02);
    check("R6 write0 keeps flag", rdata, 8'h0B);
    wr(8'h03);
    check("R6 write1 clears", rdata, 8'h0A);
    irq_en = 1'b0;
    check("R9 irq off", {7'd0, irq}, 8'h00);
    irq_en = 1'b1;

    // R6 clear in the very first recovered cycle
    cmp_async = 1'b0; cyc(4);
    check("R6 set again", rdata, 8'h03);
    cmp_async = 1'b1; cyc(2);
    wr(8'h03);
    check("R6 first-cycle clear", rdata, 8'h0A);

    // R8 no retrigger within one low period
    cmp_async = 1'b0; cyc(4);
    check("R8 first set", rdata, 8'h03);
    wr(8'h00);
    check("R8 disabled flag held", rdata, 8'h09);
    wr(8'h01);
    check("R8 cleared while off", rdata, 8'h08);
    wr(8'h02);
    cyc(6);
    check("R8 no retrigger", rdata, 8'h02);
    check("R8 no irq", {7'd0, irq}, 8'h00);
    cmp_async = 1'b1; cyc(3);
    check("R8 recovered", rdata, 8'h0A);
    cmp_async = 1'b0; cyc(3);
    check("R8 rearmed set", rdata, 8'h03);

    // R10 disabled never sets
    wr(8'h04);
    wr(8'h05);
    cyc(6);
    check("R10 disabled low", rdata, 8'h0C);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule